// File: doc/BRIEF.md
# Per-Block Two-Level Write Protection Controller

This block holds the write-protection state of a parameterised number of memory blocks. Each block has two protection levels. The first is a protect bit that software can set and clear with Protect and Unprotect commands. The second is a lock bit that a Lock command sets. A hardware write-protect pin decides whether the lock is honoured. While the pin is high, the lock is ignored and the protect bit can move freely. While the pin is low, a locked block is held protected and its protect bit cannot be changed.

Commands arrive as a two-bit opcode with a block index. The decoder that produces them sits upstream. The pin is asynchronous and passes through a two-flop synchroniser. A third register detects edges on it, and every block reacts to an edge in the same cycle. A locked block saves its protect bit when the pin falls and restores it when the pin rises. The block drives one program/erase-allowed flag per memory block, plus a two-bit status for one block picked by a select input.

Top module: `prot_ctrl`

## Requirements
- R1: After reset every block reads status 2'b01 (unlocked, protected) and every bit of `pe_allowed` is 0.
- R2: `pe_allowed[i]` is 1 exactly when block i's protect bit is 0. `status[1]` is the lock bit and `status[0]` is the protect bit of the block indexed by `sel_idx`.
- R3: Command opcodes are 2'b00 none, 2'b01 protect, 2'b10 unprotect and 2'b11 lock. While the synchronised pin is high, protect sets and unprotect clears the protect bit of the indexed block, whether or not it is locked.
- R4: A lock command sets both the lock bit and the protect bit of the indexed block at either pin level. The result reads status 2'b11.
- R5: While the synchronised pin is low, protect and unprotect commands leave a locked block unchanged, and that block reads protected.
- R6: While the synchronised pin is low, protect and unprotect set and clear the protect bit of an unlocked block normally.
- R7: On a falling pin edge every locked block becomes protected. Every unlocked block keeps its protect bit.
- R8: On a rising pin edge a locked block takes back the protect bit it held just before the pin fell. If it was locked while the pin was low, it takes back the protect bit it held just before the lock command.
- R9: No command clears a lock bit. Only reset does.
- R10: When a pin edge and a command act in the same cycle, the edge is applied first. The command is then judged under the new pin level.
- R11: A pin change that is set up before a clock edge has no effect on the block state at the second edge. It takes effect at the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_pin | input | 1 | Asynchronous write-protect pin; high overrides locks |
| cmd_op | input | 2 | Command opcode: 00 none, 01 protect, 10 unprotect, 11 lock |
| cmd_idx | input | $clog2(NBLK) | Block addressed by the command |
| sel_idx | input | $clog2(NBLK) | Block whose status is read out |
| pe_allowed | output | NBLK | Per-block program/erase-allowed flags |
| status | output | 2 | Lock (bit 1) and protect (bit 0) of the selected block |

## Verification
The assertions check four things on every cycle:
- the allowed flag of the selected block always mirrors its protect bit;
- a locked block is protected whenever the pin level in use is low;
- a lock command always leaves status 2'b11;
- a lock bit never drops.

They also check the reset defaults on leaving reset. Only the bench's scenarios can show the following:
- that the saved protect value returns on a rising edge;
- that an edge takes precedence over a command in the same cycle;
- the exact synchroniser latency;
- that unlocked blocks are left alone by pin edges.

// File: rtl/prot_ctrl.sv
module prot_ctrl #(
  parameter int NBLK = 8,
  localparam int IW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wp_pin,
  input  logic [1:0]      cmd_op,
  input  logic [IW-1:0]   cmd_idx,
  input  logic [IW-1:0]   sel_idx,
  output logic [NBLK-1:0] pe_allowed,
  output logic [1:0]      status
);
  localparam logic [1:0] OP_PROT = 2'b01;
  localparam logic [1:0] OP_UNPR = 2'b10;
  localparam logic [1:0] OP_LOCK = 2'b11;

  logic wp_s1, wp_s2, wp_q;
  logic [NBLK-1:0] prot_q, lock_q, save_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp_s1 <= 1'b1;
      wp_s2 <= 1'b1;
      wp_q  <= 1'b1;
    end else begin
      wp_s1 <= wp_pin;
      wp_s2 <= wp_s1;
      wp_q  <= wp_s2;
    end

  wire wp_fall = wp_q & ~wp_s2;
  wire wp_rise = ~wp_q & wp_s2;
  wire wp_lvl  = wp_s2;

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    logic p_e, s_e, p_n, l_n, s_n;
    wire hit = (cmd_idx == IW'(g));

    always_comb begin
      p_e = prot_q[g];
      s_e = save_q[g];
      if (wp_fall) begin
        s_e = prot_q[g];
        if (lock_q[g]) p_e = 1'b1;
      end
      if (wp_rise && lock_q[g]) p_e = save_q[g];

      p_n = p_e;
      l_n = lock_q[g];
      s_n = s_e;
      if (hit) begin
        case (cmd_op)
          OP_PROT: if (wp_lvl || !lock_q[g]) p_n = 1'b1;
          OP_UNPR: if (wp_lvl || !lock_q[g]) p_n = 1'b0;
          OP_LOCK: begin
            if (!wp_lvl && !lock_q[g]) s_n = p_e;
            l_n = 1'b1;
            p_n = 1'b1;
          end
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        prot_q[g] <= 1'b1;
        lock_q[g] <= 1'b0;
        save_q[g] <= 1'b1;
      end else begin
        prot_q[g] <= p_n;
        lock_q[g] <= l_n;
        save_q[g] <= s_n;
      end
  end

  assign pe_allowed = ~prot_q;
  assign status = (int'(sel_idx) < NBLK) ? {lock_q[sel_idx], prot_q[sel_idx]} : 2'b01;
endmodule

// File: rtl/prot_ctrl_chk.sv
module prot_ctrl_chk #(
  parameter int NBLK = 8,
  localparam int IW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wp_lvl,
  input logic [1:0]      cmd_op,
  input logic [IW-1:0]   cmd_idx,
  input logic [IW-1:0]   sel_idx,
  input logic [NBLK-1:0] pe_allowed,
  input logic [1:0]      status
);
  AST_RESET_DEFAULT: assert property (@(posedge clk) $rose(rst_n) |-> (status == 2'b01 && pe_allowed == '0)); // R1
  AST_PE_TRACKS_PROT: assert property (@(posedge clk) disable iff (!rst_n) (pe_allowed[sel_idx] == !status[0])); // R2
  AST_LOCK_CMD_RESULT: assert property (@(posedge clk) disable iff (!rst_n) (cmd_op == 2'b11 && cmd_idx == sel_idx) |=> (!$stable(sel_idx) || status == 2'b11)); // R4
  AST_LOCKED_LOW_PROT: assert property (@(posedge clk) disable iff (!rst_n) (!wp_lvl && status[1]) |-> status[0]); // R5
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n) status[1] |=> (!$stable(sel_idx) || status[1])); // R9
endmodule

bind prot_ctrl prot_ctrl_chk #(.NBLK(NBLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .wp_lvl(wp_q), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
  .sel_idx(sel_idx), .pe_allowed(pe_allowed), .status(status)
);

// File: tb/prot_ctrl_test.sv
module prot_ctrl_test;
  localparam int NBLK = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp_pin = 1'b1;
  logic [1:0] cmd_op = 2'b00;
  logic [IW-1:0] cmd_idx = '0;
  logic [IW-1:0] sel_idx = '0;
  logic [NBLK-1:0] pe_allowed;
  logic [1:0] status;

  int checks = 0;
  int failures = 0;

  prot_ctrl #(.NBLK(NBLK)) uut (
    .clk(clk), .rst_n(rst_n), .wp_pin(wp_pin), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .sel_idx(sel_idx), .pe_allowed(pe_allowed), .status(status)
  );

  always #10 clk = ~clk;

  task automatic chk(input int b, input logic [1:0] exp, input string req);
    sel_idx = IW'(b);
    #1;
    checks++;
    if (status !== exp || pe_allowed[b] !== ~exp[0]) begin
      failures++;
      $display("FAIL %s block %0d: status=%b pe=%b expected status=%b pe=%b",
               req, b, status, pe_allowed[b], exp, ~exp[0]);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input int b);
    @(negedge clk);
    cmd_op = op;
    cmd_idx = IW'(b);
    @(negedge clk);
    cmd_op = 2'b00;
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk);
    wp_pin = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    for (int b = 0; b < NBLK; b++) chk(b, 2'b01, "R1");
  endtask

  task automatic t_high;
    cmd(2'b10, 2); chk(2, 2'b00, "R3");
    cmd(2'b01, 2); chk(2, 2'b01, "R3");
    cmd(2'b10, 3); chk(3, 2'b00, "R3");
    cmd(2'b11, 3); chk(3, 2'b11, "R4");
    cmd(2'b10, 3); chk(3, 2'b10, "R3");
    cmd(2'b01, 3); chk(3, 2'b11, "R3");
    cmd(2'b10, 3); chk(3, 2'b10, "R9");
    cmd(2'b10, 4); chk(4, 2'b00, "R3");
  endtask

  task automatic t_fall;
    @(negedge clk);
    wp_pin = 1'b0;
    repeat (2) @(negedge clk);
    chk(3, 2'b10, "R11");
    @(negedge clk);
    chk(3, 2'b11, "R7");
    chk(4, 2'b00, "R7");
    chk(2, 2'b01, "R7");
  endtask

  task automatic t_low;
    cmd(2'b10, 3); chk(3, 2'b11, "R5");
    cmd(2'b01, 3); chk(3, 2'b11, "R5");
    cmd(2'b10, 2); chk(2, 2'b00, "R6");
    cmd(2'b01, 4); chk(4, 2'b01, "R6");
    cmd(2'b10, 4); chk(4, 2'b00, "R6");
    cmd(2'b11, 5); chk(5, 2'b11, "R4");
    cmd(2'b11, 4); chk(4, 2'b11, "R4");
  endtask

  task automatic t_rise;
    set_pin(1'b1);
    chk(3, 2'b10, "R8");
    chk(5, 2'b11, "R8");
    chk(4, 2'b10, "R8");
    chk(2, 2'b00, "R8");
    cmd(2'b10, 5); chk(5, 2'b10, "R9");
  endtask

  task automatic t_same_cycle;
    set_pin(1'b0);
    chk(3, 2'b11, "R7");
    @(negedge clk);
    wp_pin = 1'b1;
    repeat (2) @(negedge clk);
    cmd_op = 2'b01;
    cmd_idx = 3'd3;
    @(negedge clk);
    cmd_op = 2'b00;
    chk(3, 2'b11, "R10");
    cmd(2'b10, 3); chk(3, 2'b10, "R10");
  endtask

  initial begin
    #10000000;
    failures++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_high();
    t_fall();
    t_low();
    t_rise();
    t_same_cycle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule